// File: doc/BRIEF.md
# Two-Operand Adder with Status Flag Update

This block is the addition slice of a 16-bit processor execution unit. Each cycle in which the valid strobe is high, it adds a source operand to a destination operand. The addition runs on a full word or on a single byte. The block returns three things one clock later: the value to write back, the byte-lane write enables for a little-endian word memory, and a new status word. In the status word, the carry, zero, negative and overflow flags are rewritten, and every other bit is copied from the incoming status word.

The source operand is either the fetched register or memory value, or one of six small constants from an internal generator. Adding the all-ones constant decrements the destination. In byte mode the flags come from the low eight bits of the sum. A register destination gets the byte with a zeroed upper half. A memory destination gets the byte replicated in both lanes, and only the lane named by the address LSB is enabled. Operand fetch, decode and the register file are outside this block.

Top module: `alu_add_unit`

## Requirements
- R1: In word mode, `result` equals `(src_operand + dst) mod 2^16` and `byte_en` is `2'b11`. `addr_lsb` and `dst_is_mem` have no effect on `result` or `byte_en`.
- R2: In word mode, the flags are written into `sr_out` at these bit positions:
  - bit 0: carry out of bit 15
  - bit 1: set when all 16 result bits are zero
  - bit 2: result bit 15
  - bit 8: set when both operands have the same sign and the result has the other sign
- R3: In byte mode, the same four flags at the same bit positions are computed on the 8-bit sum only. Carry is the carry out of bit 7, negative is bit 7, zero means the byte is zero, and overflow uses bit 7 of each operand as its sign.
- R4: In byte mode with a register destination (`dst_is_mem`=0), `result` is `{8'h00, sum8}` with `sum8 = src[7:0] + dst[7:0]`, and `byte_en` is `2'b11`.
- R5: In byte mode with a memory destination, the destination byte is `dst[7:0]` when `addr_lsb`=0 and `dst[15:8]` when `addr_lsb`=1. `result` is `{sum8, sum8}`, and `byte_en` is `2'b01` for `addr_lsb`=0 and `2'b10` for `addr_lsb`=1.
- R6: When `src_is_const`=1, `const_code` replaces `src` as the source operand. The codes map 0, 1, 2, 3, 4, 5 to 0, +1, +2, +4, +8 and all ones (-1). Codes 6 and 7 give 0. In byte mode only the low 8 bits of the constant are used.
- R7: When `src_is_const`=0, `src` is the source operand and `const_code` has no effect.
- R8: Every bit of `sr_out` other than bits 0, 1, 2 and 8 equals the matching bit of `sr_in` from the accepted operation.
- R9: `valid_out` equals `valid_in` of the previous cycle. Outputs of an operation appear on the clock edge after it is presented. When `valid_in` is low, `result`, `byte_en` and `sr_out` hold their values.
- R10: A synchronous active-high `rst` clears `valid_out`, `result`, `byte_en` and `sr_out` to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation present this cycle |
| byte_mode | input | 1 | 1: 8-bit add, 0: 16-bit add |
| src_is_const | input | 1 | Take the source from the constant generator |
| const_code | input | 3 | Constant select (0,+1,+2,+4,+8,-1) |
| src | input | 16 | Register or memory source operand |
| dst | input | 16 | Destination operand (full memory word for memory byte writes) |
| dst_is_mem | input | 1 | Destination is memory rather than a register |
| addr_lsb | input | 1 | Byte address LSB of a memory destination |
| sr_in | input | 16 | Current status word |
| valid_out | output | 1 | Registered result valid |
| result | output | 16 | Write-back value |
| byte_en | output | 2 | Byte-lane write enables, bit 0 = low lane |
| sr_out | output | 16 | Updated status word |

## Verification
The bench targets the flag edges where each flag is a single bit:
- the carry out of bit 15 against bit 7;
- a zero sum produced with a carry, where an adder that tested 17 bits for zero would miss the zero flag;
- overflow from two positive and from two negative operands, where an overflow taken from the carry would disagree.

Byte writes to memory are driven at both address parities. This exposes a swapped lane enable and a design that adds the wrong half of the destination word. Register byte writes check that the upper half is cleared rather than kept. The last three constant codes and the reserved codes are checked, along with status bits that must pass through untouched, so that a mis-indexed flag position or a clobbered status bit shows up as a wrong status word.

// File: rtl/alu_add_pkg.sv
package alu_add_pkg;

   // status word bit positions (consumers decode these)
   localparam int FLAG_C = 0;
   localparam int FLAG_Z = 1;
   localparam int FLAG_N = 2;
   localparam int FLAG_V = 8;

   // constant generator codes
   localparam logic [2:0] CG_ZERO  = 3'd0;
   localparam logic [2:0] CG_ONE   = 3'd1;
   localparam logic [2:0] CG_TWO   = 3'd2;
   localparam logic [2:0] CG_FOUR  = 3'd3;
   localparam logic [2:0] CG_EIGHT = 3'd4;
   localparam logic [2:0] CG_ONES  = 3'd5;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
   } add_flags_t;

endpackage

// File: rtl/alu_const_src.sv
module alu_const_src #(
   parameter int DW = 16
) (
   input  logic          src_is_const,
   input  logic [2:0]    const_code,
   input  logic [DW-1:0] src,
   output logic [DW-1:0] opnd
);
   import alu_add_pkg::*;

   logic [DW-1:0] cval;

   always_comb begin
      case (const_code)
         CG_ONE:   cval = DW'(1);
         CG_TWO:   cval = DW'(2);
         CG_FOUR:  cval = DW'(4);
         CG_EIGHT: cval = DW'(8);
         CG_ONES:  cval = '1;
         default:  cval = '0;
      endcase
   end

   assign opnd = src_is_const ? cval : src;

endmodule

// File: rtl/alu_add_flags.sv
module alu_add_flags #(
   parameter int DW = 16,
   parameter int BW = 8
) (
   input  logic                     byte_mode,
   input  logic [DW-1:0]            a,
   input  logic [DW-1:0]            b,
   output logic [DW-1:0]            sum,
   output alu_add_pkg::add_flags_t  flg
);
   logic [DW-1:0] sw;
   logic          cw;
   logic [BW-1:0] sb;
   logic          cb;

   assign {cw, sw} = {1'b0, a} + {1'b0, b};
   assign {cb, sb} = {1'b0, a[BW-1:0]} + {1'b0, b[BW-1:0]};

   always_comb begin
      if (byte_mode) begin
         sum   = {{(DW-BW){1'b0}}, sb};
         flg.c = cb;
         flg.z = (sb == '0);
         flg.n = sb[BW-1];
         flg.v = (a[BW-1] == b[BW-1]) && (sb[BW-1] != a[BW-1]);
      end else begin
         sum   = sw;
         flg.c = cw;
         flg.z = (sw == '0);
         flg.n = sw[DW-1];
         flg.v = (a[DW-1] == b[DW-1]) && (sw[DW-1] != a[DW-1]);
      end
   end

endmodule

// File: rtl/alu_lane_pack.sv
module alu_lane_pack #(
   parameter int DW = 16,
   parameter int BW = 8
) (
   input  logic             byte_mode,
   input  logic             dst_is_mem,
   input  logic             addr_lsb,
   input  logic [DW-1:0]    sum,
   output logic [DW-1:0]    wdata,
   output logic [DW/BW-1:0] lane_en
);
   localparam int NL = DW / BW;

   logic mem_byte;
   assign mem_byte = byte_mode && dst_is_mem;

   for (genvar l = 0; l < NL; l++) begin : g_lane
      assign lane_en[l] = !mem_byte || (addr_lsb == 1'(l));
      if (l == 0) begin : g_low
         assign wdata[BW-1:0] = sum[BW-1:0];
      end else begin : g_up
         assign wdata[l*BW +: BW] = !byte_mode ? sum[l*BW +: BW] :
                                    dst_is_mem ? sum[BW-1:0] : '0;
      end
   end

endmodule

// File: rtl/alu_add_unit.sv
module alu_add_unit #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_in,
   input  logic              byte_mode,
   input  logic              src_is_const,
   input  logic [2:0]        const_code,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   input  logic              dst_is_mem,
   input  logic              addr_lsb,
   input  logic [DATA_W-1:0] sr_in,
   output logic              valid_out,
   output logic [DATA_W-1:0] result,
   output logic [1:0]        byte_en,
   output logic [DATA_W-1:0] sr_out
);
   import alu_add_pkg::*;

   localparam int NLANES = DATA_W / LANE_W;

   if ((DATA_W != 2 * LANE_W) || (DATA_W <= FLAG_V) || (NLANES != 2)) begin : g_bad_cfg
      $error("alu_add_unit: needs two lanes and room for the overflow flag");
   end

   logic [DATA_W-1:0] s_op;
   logic [DATA_W-1:0] d_op;
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] wdata;
   logic [1:0]        lane_en;
   logic [DATA_W-1:0] sr_nxt;
   add_flags_t        flg;

   alu_const_src #(.DW(DATA_W)) u_csrc (
      .src_is_const (src_is_const),
      .const_code   (const_code),
      .src          (src),
      .opnd         (s_op)
   );

   // odd memory byte: destination byte lives in the upper lane
   assign d_op = (byte_mode && dst_is_mem && addr_lsb) ?
                 {{LANE_W{1'b0}}, dst[DATA_W-1:LANE_W]} : dst;

   alu_add_flags #(.DW(DATA_W), .BW(LANE_W)) u_add (
      .byte_mode (byte_mode),
      .a         (s_op),
      .b         (d_op),
      .sum       (sum),
      .flg       (flg)
   );

   alu_lane_pack #(.DW(DATA_W), .BW(LANE_W)) u_pack (
      .byte_mode  (byte_mode),
      .dst_is_mem (dst_is_mem),
      .addr_lsb   (addr_lsb),
      .sum        (sum),
      .wdata      (wdata),
      .lane_en    (lane_en)
   );

   always_comb begin
      sr_nxt         = sr_in;
      sr_nxt[FLAG_C] = flg.c;
      sr_nxt[FLAG_Z] = flg.z;
      sr_nxt[FLAG_N] = flg.n;
      sr_nxt[FLAG_V] = flg.v;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_out <= 1'b0;
         result    <= '0;
         byte_en   <= '0;
         sr_out    <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            result  <= wdata;
            byte_en <= lane_en;
            sr_out  <= sr_nxt;
         end
      end
   end

endmodule

// File: rtl/alu_add_unit_chk.sv
module alu_add_unit_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          valid_in,
   input logic          byte_mode,
   input logic          dst_is_mem,
   input logic          addr_lsb,
   input logic [DW-1:0] sr_in,
   input logic          valid_out,
   input logic [DW-1:0] result,
   input logic [1:0]    byte_en,
   input logic [DW-1:0] sr_out
);
   localparam logic [DW-1:0] FMASK = DW'(16'h0107);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out);                                                 // R9
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> !valid_out);                                               // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> ($stable(result) && $stable(sr_out) && $stable(byte_en))); // R9
   AST_WORD_LANES: assert property (@(posedge clk) disable iff (rst)
      (valid_in && !byte_mode) |=> (byte_en == 2'b11));                        // R1
   AST_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (valid_in && !byte_mode) |=> (sr_out[1] == (result == '0)));             // R2
   AST_BYTE_NEG: assert property (@(posedge clk) disable iff (rst)
      (valid_in && byte_mode) |=> (sr_out[2] == result[7]));                   // R3
   AST_BYTE_REG_UPPER: assert property (@(posedge clk) disable iff (rst)
      (valid_in && byte_mode && !dst_is_mem) |=>
         (result[DW-1:DW/2] == '0 && byte_en == 2'b11));                        // R4
   AST_BYTE_MEM_LANE: assert property (@(posedge clk) disable iff (rst)
      (valid_in && byte_mode && dst_is_mem) |=>
         ($countones(byte_en) == 1 && byte_en[1] == $past(addr_lsb) &&
          result[DW-1:DW/2] == result[DW/2-1:0]));                              // R5
   AST_SR_PASS: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> ((sr_out & ~FMASK) == ($past(sr_in) & ~FMASK)));           // R8
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!valid_out && result == '0 && byte_en == '0 && sr_out == '0));  // R10

endmodule

bind alu_add_unit alu_add_unit_chk #(.DW(DATA_W)) chk_i (.*);

// File: tb/alu_add_unit_tb_top.sv
module alu_add_unit_tb_top;

   typedef struct packed {
      logic        bm;
      logic        kc;
      logic [2:0]  code;
      logic        mem;
      logic        lsb;
      logic [15:0] src;
      logic [15:0] dst;
      logic [15:0] sr;
      logic [15:0] eres;
      logic [1:0]  ebe;
      logic [15:0] esr;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VEC [NV] = '{
      // word mode R1/R2
      '{1'b0,1'b0,3'd0,1'b0,1'b0,16'h1234,16'h5678,16'h0000,16'h68AC,2'b11,16'h0000},
      '{1'b0,1'b0,3'd0,1'b0,1'b0,16'hFFFF,16'h0002,16'h0000,16'h0001,2'b11,16'h0001},
      '{1'b0,1'b0,3'd0,1'b0,1'b0,16'h8000,16'h8000,16'h0000,16'h0000,2'b11,16'h0103},
      '{1'b0,1'b0,3'd0,1'b0,1'b0,16'hFF00,16'h0010,16'h0000,16'hFF10,2'b11,16'h0004},
      '{1'b0,1'b0,3'd0,1'b0,1'b0,16'h7FFF,16'h0010,16'h0000,16'h800F,2'b11,16'h0104},
      '{1'b0,1'b0,3'd0,1'b0,1'b0,16'h8000,16'hFF00,16'h0000,16'h7F00,2'b11,16'h0101},
      '{1'b0,1'b0,3'd0,1'b1,1'b1,16'h0001,16'h0001,16'h0000,16'h0002,2'b11,16'h0000},
      // constants R6
      '{1'b0,1'b1,3'd5,1'b0,1'b0,16'hABCD,16'h9999,16'h0000,16'h9998,2'b11,16'h0005},
      '{1'b0,1'b1,3'd3,1'b0,1'b0,16'h0000,16'h7777,16'h0000,16'h777B,2'b11,16'h0000},
      '{1'b0,1'b1,3'd4,1'b0,1'b0,16'h0000,16'h8888,16'h0000,16'h8890,2'b11,16'h0004},
      '{1'b0,1'b1,3'd0,1'b0,1'b0,16'h1111,16'h4444,16'h0000,16'h4444,2'b11,16'h0000},
      '{1'b0,1'b1,3'd1,1'b0,1'b0,16'h0000,16'h5555,16'h0000,16'h5556,2'b11,16'h0000},
      '{1'b0,1'b1,3'd2,1'b0,1'b0,16'h0000,16'h6666,16'h0000,16'h6668,2'b11,16'h0000},
      '{1'b0,1'b1,3'd6,1'b0,1'b0,16'hFFFF,16'h1111,16'h0000,16'h1111,2'b11,16'h0000},
      // byte register R3/R4
      '{1'b1,1'b0,3'd0,1'b0,1'b0,16'h1203,16'h3406,16'h0000,16'h0009,2'b11,16'h0000},
      '{1'b1,1'b0,3'd0,1'b0,1'b0,16'h00FF,16'h0002,16'h0000,16'h0001,2'b11,16'h0001},
      '{1'b1,1'b0,3'd0,1'b0,1'b0,16'h0080,16'h0080,16'h0000,16'h0000,2'b11,16'h0103},
      '{1'b1,1'b0,3'd0,1'b0,1'b0,16'h00F0,16'h0003,16'h0000,16'h00F3,2'b11,16'h0004},
      '{1'b1,1'b0,3'd0,1'b0,1'b0,16'h007F,16'h0010,16'h0000,16'h008F,2'b11,16'h0104},
      '{1'b1,1'b0,3'd0,1'b0,1'b0,16'h0080,16'h00FF,16'h0000,16'h007F,2'b11,16'h0101},
      // byte memory R5
      '{1'b1,1'b1,3'd1,1'b1,1'b0,16'h0000,16'hAA55,16'h0000,16'h5656,2'b01,16'h0000},
      '{1'b1,1'b1,3'd2,1'b1,1'b1,16'h0000,16'hCC55,16'h0000,16'hCECE,2'b10,16'h0004},
      '{1'b1,1'b1,3'd5,1'b1,1'b1,16'h0000,16'h0155,16'h0000,16'h0000,2'b10,16'h0003},
      '{1'b1,1'b1,3'd3,1'b0,1'b0,16'h0000,16'h1234,16'h0000,16'h0038,2'b11,16'h0000},
      // status pass-through R8
      '{1'b0,1'b0,3'd0,1'b0,1'b0,16'h0001,16'h0001,16'hFFFF,16'h0002,2'b11,16'hFEF8},
      '{1'b1,1'b0,3'd0,1'b1,1'b0,16'h0010,16'h7F70,16'h0200,16'h8080,2'b01,16'h0304},
      '{1'b0,1'b1,3'd7,1'b0,1'b0,16'h5A5A,16'h2222,16'h0000,16'h2222,2'b11,16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_in = 1'b0;
   logic        byte_mode = 1'b0;
   logic        src_is_const = 1'b0;
   logic [2:0]  const_code = '0;
   logic [15:0] src = '0;
   logic [15:0] dst = '0;
   logic        dst_is_mem = 1'b0;
   logic        addr_lsb = 1'b0;
   logic [15:0] sr_in = '0;
   logic        valid_out;
   logic [15:0] result;
   logic [1:0]  byte_en;
   logic [15:0] sr_out;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   alu_add_unit dut_i (
      .clk(clk), .rst(rst), .valid_in(valid_in), .byte_mode(byte_mode),
      .src_is_const(src_is_const), .const_code(const_code), .src(src),
      .dst(dst), .dst_is_mem(dst_is_mem), .addr_lsb(addr_lsb), .sr_in(sr_in),
      .valid_out(valid_out), .result(result), .byte_en(byte_en), .sr_out(sr_out)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      valid_in     = 1'b1;
      byte_mode    = v.bm;
      src_is_const = v.kc;
      const_code   = v.code;
      src          = v.src;
      dst          = v.dst;
      dst_is_mem   = v.mem;
      addr_lsb     = v.lsb;
      sr_in        = v.sr;
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL R9 watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      string rl;
      string fl;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10", "reset valid_out", {15'd0, valid_out}, 16'd0);
      check("R10", "reset result", result, 16'h0000);
      check("R10", "reset byte_en", {14'd0, byte_en}, 16'd0);
      check("R10", "reset sr_out", sr_out, 16'h0000);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         @(posedge clk);
         @(negedge clk);
         rl = VEC[i].kc ? "R6" : (VEC[i].bm ? (VEC[i].mem ? "R5" : "R4") : "R1");
         fl = ((VEC[i].sr & 16'hFEF8) != 16'h0) ? "R8" : (VEC[i].bm ? "R3" : "R2");
         check("R9", $sformatf("vec%0d valid_out", i), {15'd0, valid_out}, 16'd1);
         check(rl, $sformatf("vec%0d result", i), result, VEC[i].eres);
         check(rl, $sformatf("vec%0d byte_en", i), {14'd0, byte_en}, {14'd0, VEC[i].ebe});
         check(fl, $sformatf("vec%0d sr_out", i), sr_out, VEC[i].esr);
      end

      // R9: idle cycle holds outputs, drops valid
      valid_in = 1'b0;
      src = 16'h1357;
      dst = 16'h2468;
      sr_in = 16'hFFFF;
      @(posedge clk);
      @(negedge clk);
      check("R9", "idle valid_out", {15'd0, valid_out}, 16'd0);
      check("R9", "idle result hold", result, VEC[NV-1].eres);
      check("R9", "idle sr hold", sr_out, VEC[NV-1].esr);

      // R7: register source with a stray constant code
      valid_in = 1'b1;
      byte_mode = 1'b0;
      src_is_const = 1'b0;
      const_code = 3'd5;
      src = 16'h0100;
      dst = 16'h0200;
      dst_is_mem = 1'b0;
      addr_lsb = 1'b0;
      sr_in = 16'h0000;
      @(posedge clk);
      @(negedge clk);
      check("R7", "register source result", result, 16'h0300);
      check("R7", "register source sr", sr_out, 16'h0000);

      // R10: reset while an operation is presented
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R10", "mid reset valid_out", {15'd0, valid_out}, 16'd0);
      check("R10", "mid reset result", result, 16'h0000);
      check("R10", "mid reset sr_out", sr_out, 16'h0000);
      rst = 1'b0;
      valid_in = 1'b0;
      @(negedge clk);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule